// File: doc/BRIEF.md
# Segmented Waveform RAM Address Sequencer

This block produces read addresses for a waveform memory that is split into several segments. Each segment is described by a profile entry. The entry holds a first address, a last address and a step-rate count. A segment-select input chooses which profile is active. An internal pacing timer decides when the address moves on. The address climbs by one from the first address to the last address. On the next timer expiry it returns to the first address, and the loop continues without end.

A sweep is restarted by a one-cycle update strobe, or by any change of the segment-select input. The segment-select input may be asynchronous, so it passes through a two-flop synchronizer before it is used. Software loads the profiles through a plain write port. The memory array itself and the data path that follows it are outside this block.

Top module: `wave_addr_seq`

## Requirements
- R1: After reset `rd_valid` is 0 and `rd_addr` is 0. Both stay so until the first restart. Writing profiles does not start a sweep.
- R2: When `cfg_we` is high at a rising edge, entry `cfg_idx` takes `cfg_start`, `cfg_end` and `cfg_rate`. A later restart on that entry uses the new values.
- R3: When `upd_stb` is high at a rising edge, `rd_addr` equals the first address of the active segment after that edge, and `rd_valid` is 1 from then on.
- R4: The pacing period P is `cfg_rate` clock cycles, and a rate of 0 counts as P = 1. After a restart at edge E, the address seen after edge E+j is entry number floor(j/P) of the sweep.
- R5: Between restarts the address only changes on a timer expiry. Each change adds exactly one, except at the wrap.
- R6: A timer expiry while the address equals the last address returns it to the first address. This repeats indefinitely.
- R7: Any change of `seg_sel`, in either direction on any bit, is sampled by two flip-flops. If it changes before edge E0, the old sweep continues through edges E0 and E1. Edge E2 restarts at the first address of the new segment. One change gives exactly one restart.
- R8: An update strobe in the same cycle as a detected `seg_sel` change gives a single restart on the newly selected segment.
- R9: A segment whose last address equals its first address keeps that address through every expiry.
- R10: Every restart reloads the timer. The first address is therefore held a full P cycles, even when the restart lands in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Profile write enable |
| cfg_idx | input | SEL_W (3) | Profile entry to write |
| cfg_start | input | ADDR_W (10) | First address of the segment |
| cfg_end | input | ADDR_W (10) | Last address of the segment |
| cfg_rate | input | RATE_W (16) | Pacing period in cycles; 0 counts as 1 |
| seg_sel | input | SEL_W (3) | Active segment select, may be asynchronous |
| upd_stb | input | 1 | Restart strobe |
| rd_addr | output | ADDR_W (10) | Waveform memory read address |
| rd_valid | output | 1 | High once a sweep has started |

## Verification
The hardest case to reach from the ports is a restart that overlaps other activity. One form is a segment change arriving while the previous sweep is still between timer expiries. Another is an update strobe landing in exactly the cycle in which the synchronized change becomes visible. The bench gets there by counting edges from each `seg_sel` drive. It keeps checking the old sweep through the two synchronizer cycles, and it places the strobe on the third edge for the coincidence case. Every sample is compared with an address computed as first + (floor(j/P) mod length), using the edge count j since the restart.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;

   // Reload value of the pacing counter: period minus one, with a zero rate
   // treated as a one-cycle period.
   function automatic logic [31:0] reload_of(input logic [31:0] rate);
      return (rate == 32'd0) ? 32'd0 : rate - 32'd1;
   endfunction

endpackage

// File: rtl/wseq_profile_bank.sv
module wseq_profile_bank #(
   parameter int NUM_SEG = 8,
   parameter int ADDR_W  = 10,
   parameter int RATE_W  = 16,
   localparam int SEL_W  = $clog2(NUM_SEG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_start,
   input  logic [ADDR_W-1:0] wr_end,
   input  logic [RATE_W-1:0] wr_rate,
   input  logic [SEL_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_start,
   output logic [ADDR_W-1:0] rd_end,
   output logic [RATE_W-1:0] rd_rate
);

   logic [ADDR_W-1:0] start_q [NUM_SEG];
   logic [ADDR_W-1:0] end_q   [NUM_SEG];
   logic [RATE_W-1:0] rate_q  [NUM_SEG];

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_q[i] <= '0;
            end_q[i]   <= '0;
            rate_q[i]  <= '0;
         end else if (wr_en && (wr_idx == SEL_W'(i))) begin
            start_q[i] <= wr_start;
            end_q[i]   <= wr_end;
            rate_q[i]  <= wr_rate;
         end
      end
   end

   assign rd_start = start_q[rd_idx];
   assign rd_end   = end_q[rd_idx];
   assign rd_rate  = rate_q[rd_idx];

endmodule

// File: rtl/wseq_sel_sync.sv
module wseq_sel_sync #(
   parameter int SEL_W  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_async,
   output logic [SEL_W-1:0] sel_sync,
   output logic             sel_changed
);

   logic [SEL_W-1:0] stage_q [STAGES];
   logic [SEL_W-1:0] prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= sel_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign sel_sync    = stage_q[STAGES-1];
   assign sel_changed = (stage_q[STAGES-1] != prev_q);

endmodule

// File: rtl/wseq_pacer.sv
module wseq_pacer #(
   parameter int RATE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   import wseq_pkg::*;

   logic [RATE_W-1:0] cnt_q;
   logic [RATE_W-1:0] reload;

   assign reload = RATE_W'(reload_of(32'(rate)));
   assign tick   = run && !restart && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (restart)      cnt_q <= reload;
      else if (run) begin
         if (cnt_q == '0)    cnt_q <= reload;
         else                cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/wave_addr_seq.sv
module wave_addr_seq #(
   parameter int NUM_SEG     = 8,
   parameter int ADDR_W      = 10,
   parameter int RATE_W      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(NUM_SEG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_start,
   input  logic [ADDR_W-1:0] cfg_end,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic [SEL_W-1:0]  seg_sel,
   input  logic              upd_stb,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid
);
   import wseq_pkg::*;

   if (NUM_SEG < 2 || (1 << SEL_W) != NUM_SEG) begin : g_bad_seg
      $error("NUM_SEG must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 1 || RATE_W < 1 || RATE_W > 32) begin : g_bad_width
      $error("ADDR_W must be positive and RATE_W within 1..32");
   end

   logic [SEL_W-1:0]  act_sel;
   logic              sel_changed;
   logic [ADDR_W-1:0] act_start, act_end;
   logic [RATE_W-1:0] act_rate;
   logic              restart, tick;
   seq_state_t        state_q;
   logic [ADDR_W-1:0] addr_q;

   wseq_sel_sync #(.SEL_W(SEL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sel_async(seg_sel),
      .sel_sync(act_sel), .sel_changed(sel_changed)
   );

   wseq_profile_bank #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W), .RATE_W(RATE_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
      .wr_start(cfg_start), .wr_end(cfg_end), .wr_rate(cfg_rate),
      .rd_idx(act_sel), .rd_start(act_start), .rd_end(act_end), .rd_rate(act_rate)
   );

   // A strobe and a detected change in one cycle merge into one restart;
   // the bank already reads the newly synchronized selection.
   assign restart = upd_stb || sel_changed;

   wseq_pacer #(.RATE_W(RATE_W)) u_pacer (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .run(state_q == SEQ_RUN), .rate(act_rate), .tick(tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         addr_q  <= '0;
      end else if (restart) begin
         state_q <= SEQ_RUN;
         addr_q  <= act_start;
      end else if (tick) begin
         addr_q  <= (addr_q == act_end) ? act_start : addr_q + 1'b1;
      end
   end

   assign rd_addr  = addr_q;
   assign rd_valid = (state_q == SEQ_RUN);

endmodule

// File: rtl/wave_addr_seq_chk.sv
module wave_addr_seq_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_stb,
   input logic              restart,
   input logic              tick,
   input logic [ADDR_W-1:0] act_start,
   input logic [ADDR_W-1:0] act_end,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_valid
);

   a_r1_idle_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_addr == '0);

   a_r1_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rd_valid);

   a_r3_strobe_loads_start: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |=> rd_valid && rd_addr == $past(act_start));

   a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !restart && !tick |=> $stable(rd_addr));

   a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !restart && tick && rd_addr != act_end |=> rd_addr == $past(rd_addr) + 1'b1);

   a_r6_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !restart && tick && rd_addr == act_end |=> rd_addr == $past(act_start));

endmodule

bind wave_addr_seq wave_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .restart(restart), .tick(tick),
   .act_start(act_start), .act_end(act_end), .rd_addr(rd_addr), .rd_valid(rd_valid)
);

// File: tb/wave_addr_seq_test.sv
module wave_addr_seq_test;

   localparam int NS = 8, AW = 10, RW = 16, SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [SW-1:0] cfg_idx = '0;
   logic [AW-1:0] cfg_start = '0, cfg_end = '0;
   logic [RW-1:0] cfg_rate = '0;
   logic [SW-1:0] seg_sel = '0;
   logic          upd_stb = 1'b0;
   logic [AW-1:0] rd_addr;
   logic          rd_valid;

   int n_run = 0, n_fail = 0;
   int j = 0, exp_seg = 0;
   bit active = 0;
   int p_start [NS], p_len [NS], p_rate [NS];

   always #5 clk = ~clk;

   wave_addr_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_rate(cfg_rate),
      .seg_sel(seg_sel), .upd_stb(upd_stb), .rd_addr(rd_addr), .rd_valid(rd_valid)
   );

   task automatic check(input string tag);
      int per, ea;
      n_run++;
      if (!active) begin
         if (rd_valid !== 1'b0 || rd_addr !== '0) begin
            n_fail++;
            $display("FAIL %s: valid=%0b addr=%0d expected valid=0 addr=0", tag, rd_valid, rd_addr);
         end
      end else begin
         per = (p_rate[exp_seg] == 0) ? 1 : p_rate[exp_seg];
         ea  = p_start[exp_seg] + ((j / per) % p_len[exp_seg]);
         if (rd_valid !== 1'b1 || rd_addr !== AW'(ea)) begin
            n_fail++;
            $display("FAIL %s: seg=%0d j=%0d valid=%0b addr=%0d expected valid=1 addr=%0d",
                     tag, exp_seg, j, rd_valid, rd_addr, ea);
         end
      end
   endtask

   task automatic tick(input string tag);
      @(negedge clk);
      j++;
      check(tag);
   endtask

   task automatic write_prof(input int i, input int st, input int len, input int rate);
      p_start[i] = st; p_len[i] = len; p_rate[i] = rate;
      cfg_we = 1'b1; cfg_idx = SW'(i);
      cfg_start = AW'(st); cfg_end = AW'(st + len - 1); cfg_rate = RW'(rate);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_upd(input string tag);
      upd_stb = 1'b1; exp_seg = int'(seg_sel); j = -1; active = 1;
      tick(tag);
      upd_stb = 1'b0;
   endtask

   // seg_sel changes now; old sweep must continue for two edges (R7)
   task automatic change_sel(input int s, input bit with_upd, input string tag);
      seg_sel = SW'(s);
      tick(tag);
      tick(tag);
      if (with_upd) upd_stb = 1'b1;
      exp_seg = s; j = -1; active = 1;
      tick(tag);
      upd_stb = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset");
      // profile layout: seg i starts at i*37+3, length (i%4)+1, rate i%3;
      // seg 6 sits at the top of the address space
      for (int i = 0; i < NS; i++) begin
         if (i == 6) write_prof(i, 1021, 3, 2);
         else        write_prof(i, i * 37 + 3, (i % 4) + 1, i % 3);
      end
      for (int k = 0; k < 4; k++) tick("R1 idle after writes");

      pulse_upd("R3 strobe start seg0");
      for (int k = 0; k < 6; k++) tick("R9 single address seg0");

      for (int s = 1; s < NS; s++) begin
         change_sel(s, 0, "R7 select change");
         for (int k = 0; k < 3 * p_len[s] * 3 + 2; k++) tick("R6 wrap sweep");
      end

      change_sel(3, 0, "R7 abort mid sweep");
      for (int k = 0; k < 5; k++) tick("R4 rate zero pacing");
      change_sel(5, 0, "R7 abort mid sweep");
      tick("R10 pre strobe");
      pulse_upd("R10 restart mid period");
      for (int k = 0; k < 10; k++) tick("R10 full first period");

      change_sel(2, 1, "R8 coincident strobe and change");
      for (int k = 0; k < 20; k++) tick("R8 single restart");

      change_sel(4, 0, "R9 single address seg4");
      for (int k = 0; k < 8; k++) tick("R9 hold seg4");

      write_prof(2, 500, 3, 4);
      j++; check("R2 running seg unaffected");
      change_sel(2, 0, "R2 rewritten profile");
      for (int k = 0; k < 30; k++) tick("R2 R5 new profile sweep");

      change_sel(0, 0, "R7 falling bits");
      pulse_upd("R3 repeated strobe");
      for (int k = 0; k < 4; k++) tick("R3 after strobe");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule